// File: doc/BRIEF.md
# Four-Level Nested Interrupt Arbiter

This block sits between up to nine interrupt request lines and a small 8-bit processor core. Software programs a per-source enable mask, a master enable bit and a two-bit priority level for each source through a narrow register write port. The block records which priority levels the core is servicing at the moment.

On every instruction-start strobe from the core, the arbiter picks a winner, provided no request is already outstanding. The winner is the pending, enabled source with the highest level that is strictly above the highest level now in service. Among sources at that level, the lowest source index wins. The arbiter then raises a registered request with the winner's index and holds both until the core acknowledges. The acknowledge marks the winner's level as in service. A return strobe from the core retires the highest in-service level.

A separate combinational wake output tells a sleeping core that an enabled request is pending.

Top module: `nested_irq_arb`

## Requirements
- R1: After reset, req_o and wake_o are 0, every enable bit, the master enable and every priority bit are 0, and no level is in service.
- R2: A source whose enable bit is 0 never wins arbitration and never drives wake_o.
- R3: When the master enable is 0, no request is raised and wake_o stays 0, whatever the per-source enables are.
- R4: The register port decodes wr_sel_i as follows: 0 writes the enables into wr_data_i[N_SRC-1:0] and the master enable into bit N_SRC; 1 writes the low priority bits; 2 writes the high priority bits; 3 is ignored. A source's level is {high bit, low bit}.
- R5: Among eligible pending sources, the one at the higher level wins.
- R6: Among eligible sources at the same highest level, the lowest index wins.
- R7: While any level is in service, only a request at a level strictly above the highest in-service level can be raised.
- R8: While level 3 is in service, no request is raised.
- R9: A new decision is taken only on a clock edge where insn_start_i is 1 and no request is outstanding. req_o and src_o then hold, even if the request line drops, until ack_i. ack_i clears req_o and marks the winner's level as in service.
- R10: reti_i clears the highest in-service level, so the next decision is measured against the level below it.
- R11: wake_o equals sleep_i AND (at least one source is requesting, enabled, and the master enable is set), with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_sel_i | input | 2 | Configuration register select |
| wr_data_i | input | N_SRC+1 | Configuration write data |
| irq_i | input | N_SRC | Level-sensitive request lines |
| insn_start_i | input | 1 | Instruction boundary strobe |
| ack_i | input | 1 | Core accepts the outstanding request |
| reti_i | input | 1 | Core leaves the current service routine |
| sleep_i | input | 1 | Core is idle or powered down |
| req_o | output | 1 | Vectored request to the core |
| src_o | output | $clog2(N_SRC) | Index of the requesting source |
| wake_o | output | 1 | Wake request for a sleeping core |

## Verification
The assertions check the following on every cycle:
- the request and its index hold until acknowledged;
- a cleared master enable, or level 3 in service, yields no candidate;
- any candidate is enabled, requesting, and above the in-service level;
- each return strobe retires exactly one in-service level.

Only the bench scenarios can show that the chosen source is the right one among competitors. That covers level ordering, tie-breaking by index, the register field decoding and the order in which nested levels are retired. The bench compares each of these against a reference model while configuration, requests and acknowledge/return sequences vary.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int unsigned N_LVL = 4;
  localparam int unsigned LVL_W = 2;
  typedef logic [LVL_W-1:0] lvl_t;
  typedef enum logic [1:0] {
    SEL_EN  = 2'd0,
    SEL_PLO = 2'd1,
    SEL_PHI = 2'd2,
    SEL_NONE = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_arb_pkg::*;
#(
  parameter int unsigned N_SRC = 9
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [1:0]                  wr_sel_i,
  input  logic [N_SRC:0]              wr_data_i,
  output logic [N_SRC-1:0]            en_o,
  output logic                        gen_o,
  output logic [N_SRC-1:0][LVL_W-1:0] lvl_o
);
  logic [N_SRC-1:0] en_q, plo_q, phi_q;
  logic             gen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      gen_q <= 1'b0;
      plo_q <= '0;
      phi_q <= '0;
    end else if (wr_en_i) begin
      unique case (cfg_sel_e'(wr_sel_i))
        SEL_EN: begin
          en_q  <= wr_data_i[N_SRC-1:0];
          gen_q <= wr_data_i[N_SRC];
        end
        SEL_PLO: plo_q <= wr_data_i[N_SRC-1:0];
        SEL_PHI: phi_q <= wr_data_i[N_SRC-1:0];
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < N_SRC; g++) begin : g_lvl
    assign lvl_o[g] = {phi_q[g], plo_q[g]};
  end

  assign en_o  = en_q;
  assign gen_o = gen_q;
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
  import irq_arb_pkg::*;
#(
  parameter int unsigned N_SRC = 9,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]            elig_i,
  input  logic [N_SRC-1:0][LVL_W-1:0] lvl_i,
  input  logic                        floor_vld_i,
  input  lvl_t                        floor_i,
  output logic                        win_vld_o,
  output logic [IDX_W-1:0]            win_idx_o,
  output lvl_t                        win_lvl_o
);
  // Scan from the top index down; ">=" lets a lower index take a tie.
  always_comb begin
    win_vld_o = 1'b0;
    win_idx_o = '0;
    win_lvl_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (elig_i[i] && (!floor_vld_i || lvl_i[i] > floor_i) &&
          (!win_vld_o || lvl_i[i] >= win_lvl_o)) begin
        win_vld_o = 1'b1;
        win_idx_o = IDX_W'(i);
        win_lvl_o = lvl_i[i];
      end
    end
  end
endmodule

// File: rtl/irq_isr_track.sv
module irq_isr_track
  import irq_arb_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_i,
  input  lvl_t             acc_lvl_i,
  input  logic             reti_i,
  output logic [N_LVL-1:0] isr_o,
  output logic             top_vld_o,
  output lvl_t             top_lvl_o
);
  logic [N_LVL-1:0] isr_q, isr_d;

  always_comb begin
    top_vld_o = 1'b0;
    top_lvl_o = '0;
    for (int l = 0; l < N_LVL; l++) begin
      if (isr_q[l]) begin
        top_vld_o = 1'b1;
        top_lvl_o = lvl_t'(l);
      end
    end
  end

  always_comb begin
    isr_d = isr_q;
    if (reti_i && top_vld_o) isr_d[top_lvl_o] = 1'b0;
    if (acc_i) isr_d[acc_lvl_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) isr_q <= '0;
    else         isr_q <= isr_d;
  end

  assign isr_o = isr_q;

  assert_reti_one_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && !acc_i && (isr_q != '0)) |=>
      ($countones(isr_q) == $countones($past(isr_q)) - 1));
endmodule

// File: rtl/nested_irq_arb.sv
module nested_irq_arb
  import irq_arb_pkg::*;
#(
  parameter int unsigned N_SRC = 9,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [N_SRC:0]   wr_data_i,
  input  logic [N_SRC-1:0] irq_i,
  input  logic             insn_start_i,
  input  logic             ack_i,
  input  logic             reti_i,
  input  logic             sleep_i,
  output logic             req_o,
  output logic [IDX_W-1:0] src_o,
  output logic             wake_o
);
  logic [N_SRC-1:0]            en, elig;
  logic                        gen;
  logic [N_SRC-1:0][LVL_W-1:0] lvl;
  logic                        pick_vld, top_vld, acc;
  logic [IDX_W-1:0]            pick_idx;
  lvl_t                        pick_lvl, top_lvl, req_lvl_q;
  logic [N_LVL-1:0]            isr;
  logic                        req_q;
  logic [IDX_W-1:0]            src_q;

  irq_cfg_regs #(.N_SRC(N_SRC)) u_cfg (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i,
    .en_o(en), .gen_o(gen), .lvl_o(lvl)
  );

  assign elig = irq_i & en & {N_SRC{gen}};

  irq_prio_pick #(.N_SRC(N_SRC)) u_pick (
    .elig_i(elig), .lvl_i(lvl), .floor_vld_i(top_vld), .floor_i(top_lvl),
    .win_vld_o(pick_vld), .win_idx_o(pick_idx), .win_lvl_o(pick_lvl)
  );

  assign acc = req_q && ack_i;

  irq_isr_track u_isr (
    .clk_i, .rst_ni, .acc_i(acc), .acc_lvl_i(req_lvl_q), .reti_i,
    .isr_o(isr), .top_vld_o(top_vld), .top_lvl_o(top_lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q     <= 1'b0;
      src_q     <= '0;
      req_lvl_q <= '0;
    end else if (acc) begin
      req_q <= 1'b0;
    end else if (!req_q && insn_start_i && pick_vld) begin
      req_q     <= 1'b1;
      src_q     <= pick_idx;
      req_lvl_q <= pick_lvl;
    end
  end

  assign req_o  = req_q;
  assign src_o  = src_q;
  assign wake_o = sleep_i && (elig != '0);

  assert_hold_until_ack_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && !ack_i) |=> (req_q && $stable(src_q)));
  assert_top_level_blocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    isr[N_LVL-1] |-> !pick_vld);
  assert_master_mask_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gen |-> (!pick_vld && !wake_o));
  assert_winner_enabled_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pick_vld |-> (en[pick_idx] && irq_i[pick_idx]));
  assert_above_floor_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pick_vld && top_vld) |-> (pick_lvl > top_lvl));
endmodule

// File: tb/sim_nested_irq_arb.sv
`timescale 1ns/1ps
module sim_nested_irq_arb;
  localparam int N = 9;
  localparam int IW = $clog2(N);

  logic clk = 0, rst_ni = 0;
  logic wr_en = 0, insn = 0, ack = 0, reti = 0, sleep = 0;
  logic [1:0] wr_sel = 0;
  logic [N:0] wr_data = 0;
  logic [N-1:0] irq = 0;
  logic req_o, wake_o;
  logic [IW-1:0] src_o;

  always #4 clk = ~clk;

  nested_irq_arb #(.N_SRC(N)) u0 (
    .clk_i(clk), .rst_ni, .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .irq_i(irq), .insn_start_i(insn), .ack_i(ack), .reti_i(reti), .sleep_i(sleep),
    .req_o, .src_o, .wake_o
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [N-1:0] m_en = 0, m_plo = 0, m_phi = 0;
  logic m_gen = 0, m_req = 0;
  logic [3:0] m_isr = 0;
  int m_src = 0, m_lvl = 0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int top_isr();
    int t = -1;
    for (int l = 0; l < 4; l++) if (m_isr[l]) t = l;
    return t;
  endfunction

  // returns winner index or -1
  function automatic int model_pick(output int wl);
    int best = -1, fl = top_isr();
    wl = 0;
    for (int i = 0; i < N; i++) begin
      int l = {m_phi[i], m_plo[i]};
      if (irq[i] && m_en[i] && m_gen && l > fl && (best < 0 || l > wl)) begin
        best = i;
        wl = l;
      end
    end
    return best;
  endfunction

  function automatic bit model_wake();
    return sleep && ((irq & m_en & {N{m_gen}}) != 0);
  endfunction

  task automatic wr(input logic [1:0] sel, input logic [N:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    case (sel)
      2'd0: begin m_en = d[N-1:0]; m_gen = d[N]; end
      2'd1: m_plo = d[N-1:0];
      2'd2: m_phi = d[N-1:0];
      default: ;
    endcase
  endtask

  task automatic do_insn(string tag);
    int w, wl;
    @(negedge clk);
    insn = 1;
    if (!m_req) begin
      w = model_pick(wl);
      if (w >= 0) begin m_req = 1; m_src = w; m_lvl = wl; end
    end
    @(negedge clk);
    insn = 0;
    chk({tag, " req"}, int'(req_o), int'(m_req));
    if (m_req) chk({tag, " src"}, int'(src_o), m_src);
  endtask

  task automatic do_ack(string tag);
    @(negedge clk);
    ack = 1;
    if (m_req) begin m_isr[m_lvl] = 1; m_req = 0; end
    @(negedge clk);
    ack = 0;
    chk({tag, " req after ack"}, int'(req_o), 0);
  endtask

  task automatic do_reti();
    int t;
    @(negedge clk);
    reti = 1;
    t = top_isr();
    if (t >= 0) m_isr[t] = 0;
    @(negedge clk);
    reti = 0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    chk("R1 req_o reset", int'(req_o), 0);
    chk("R1 wake_o reset", int'(wake_o), 0);
    irq = '1; sleep = 1;
    do_insn("R1 cleared config");
    @(negedge clk);
    chk("R1 wake cleared", int'(wake_o), 0);

    // master enable off with all sources enabled
    wr(2'd0, {1'b0, {N{1'b1}}});
    do_insn("R3 master off");
    chk("R3 wake masked", int'(wake_o), 0);

    // sel 3 ignored: write would set master, must not
    wr(2'd3, '1);
    do_insn("R4 sel3 ignored");

    // src2 lvl1, src5 lvl2, src7 lvl2, src8 lvl3 later
    wr(2'd1, {1'b0, 9'b000000100});
    wr(2'd2, {1'b0, 9'b010100000});
    wr(2'd0, {1'b1, 9'b011111111});
    @(negedge clk);
    chk("R11 wake", int'(wake_o), 1);
    do_insn("R5 R6 level then index");
    chk("R4 R6 winner 5", int'(src_o), 5);
    irq = '0;
    do_insn("R9 hold after drop");
    chk("R9 still 5", int'(src_o), 5);
    chk("R11 wake off", int'(wake_o), 0);
    do_ack("R9");
    irq = '1;
    do_insn("R7 same level blocked");
    chk("R7 no req", int'(req_o), 0);
    // disable src5 in config: src7 would win only above floor; raise src8 to lvl3
    wr(2'd1, {1'b0, 9'b100000100});
    wr(2'd2, {1'b0, 9'b110100000});
    wr(2'd0, {1'b1, 9'b111011111});
    do_insn("R7 higher preempts");
    chk("R7 src8", int'(src_o), 8);
    do_ack("R8");
    do_insn("R8 level3 blocks");
    chk("R8 no req", int'(req_o), 0);
    do_reti();
    do_insn("R10 after reti lvl3");
    chk("R10 src8 again", int'(src_o), 8);
    do_ack("R10");
    do_reti();
    do_reti();
    wr(2'd2, {1'b0, 9'b010100000});
    do_insn("R2 src5 disabled");
    chk("R2 src7", int'(src_o), 7);
    do_ack("R2");
    do_reti();

    // random phase
    for (int it = 0; it < 600; it++) begin
      int a = $urandom_range(0, 9);
      @(negedge clk);
      irq = N'($urandom);
      sleep = 1'($urandom);
      #1;
      chk("R11 wake random", int'(wake_o), int'(model_wake()));
      case (a)
        0: wr(2'd0, {1'($urandom_range(0, 7) != 0), N'($urandom)});
        1: wr(2'd1, {1'b0, N'($urandom)});
        2: wr(2'd2, {1'b0, N'($urandom)});
        3, 4, 5: do_insn("R5 R6 R7 R8 random");
        6, 7: do_ack("R9 random");
        default: do_reti();
      endcase
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule